// File: doc/BRIEF.md
# Multi-width GPIO port and pad controller

This block is a register-mapped controller for up to 64 general-purpose pads. A simple bus slave gives software three windows. The first holds one configuration word per pad. The second is the output data storage. The third is a read-only view of the pad levels.

The output and input data are grouped into 32-bit ports. Each port can be reached as one 32-bit word, as two 16-bit halves or as four bytes. Every view aliases the same bits, so any access finishes in one bus transfer. Byte lanes are big-endian: offset 0 of a port holds bits 31:24.

One configuration write sets all of a pad's electrical behaviour together:
- the choice between GPIO and the alternate function;
- output enable and open-drain operation;
- pull enable and pull direction;
- the slew bit;
- whether the safe-mode input turns the driver off.

The block also computes a modelled pad level from the driver, the pull and the external level. That level is synchronised into the input view and returned on the per-pad alternate-function input.

Top module: `gpio_portctl`

## Requirements
- R1: After reset, every configuration word and every output data bit is zero, no pad driver is enabled, and the read data output is zero.
- R2: Address decode uses bus_addr[11:8] to pick the window: 0 is configuration, 1 is output data and 2 is input data. A 32-bit access (bus_size = 2) at window offset 4*w reaches all 32 bits of port w, and pad 32*w+b is bit b of that port.
- R3: An 8-bit access (bus_size = 0) at byte offset o of a port (o = bus_addr[1:0]) reaches port bits [31-8o : 24-8o]. Write data and read data sit in bits 7:0, and a write changes no other bit of the port.
- R4: A 16-bit access (bus_size = 1) with bus_addr[1] = 0 reaches port bits 31:16, and with bus_addr[1] = 1 it reaches bits 15:0. Data sits in bits 15:0 of the bus word.
- R5: The configuration word of pad i sits at offset 4*i of window 0. One write of any size stores bus_wdata[6:0] into it, and a read returns that value zero-extended. Field bits are: 0 selects the alternate function, 1 enables the output, 2 selects open-drain, 3 enables the pull, 4 selects pull-up (1) or pull-down (0), 5 is the slew bit (driven on pad_slew), and 6 enables safe-mode shutdown.
- R6: In GPIO mode (bit 0 = 0), the driver of a pad is enabled by its output enable bit and drives its output data bit.
- R7: In alternate mode (bit 0 = 1), driver enable and driven value come from alt_oe and alt_out. alt_in always carries the modelled pad level.
- R8: In open-drain mode, a 1 to be driven releases the driver (pad_drv_en low), and only a 0 is actively driven.
- R9: While safe_mode is high, every pad whose safe bit is set has its driver disabled whatever its other settings. Pads without the bit are unaffected.
- R10: The modelled pad level is the driven value when the driver is enabled. Otherwise it is the pull direction when the pull is enabled, and pad_ext when the pull is disabled.
- R11: Input data reads return the pad levels held in a synchronising register that samples them every clock. A level change that shows up together with a read request is seen by the next read, not that one.
- R12: Reads of windows 3 to 15, of ports beyond the last implemented pad, of configuration words of pads not implemented, and of unimplemented bits of a partial port return zero. Writes to any of these change nothing.
- R13: Read data appears on bus_rdata in the cycle after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_rdata | output | 32 | Read data, right-justified, registered |
| safe_mode | input | 1 | Safe-mode request |
| alt_out | input | NPADS | Alternate-function output value per pad |
| alt_oe | input | NPADS | Alternate-function output enable per pad |
| alt_in | output | NPADS | Modelled pad level to alternate functions |
| pad_ext | input | NPADS | Level applied to the pad from outside |
| pad_drv_en | output | NPADS | Pad driver enable |
| pad_drv_val | output | NPADS | Value driven when enabled |
| pad_slew | output | NPADS | Slew bit per pad |
| pad_level | output | NPADS | Modelled pad level |

## Verification
The aliasing is tried with the following patterns:
- A word with distinct byte values is written, then read back as word, halves and bytes. A swapped lane or a little-endian mapping shows up in the returned value.
- Byte and halfword writes into a known word are read back as a whole word. This separates a correct lane mask from one that clears or smears neighbouring bytes.
- All ones is written to the partial upper port and to the unmapped addresses. Masking of unimplemented pads and ignored writes are then visible in read data.

The pad checks take one data pattern through each configuration, with pad_ext held high. In that state a pull-down, an open-drain release, an alternate-driven 0 and a safe-mode shutdown each give a different level or enable from the plain GPIO case.

The input view is tested by changing pad_ext in the same cycle as a read. This tells the one-clock synchroniser apart from a direct path.

// File: rtl/gpio_portctl.sv
module gpio_portctl #(
  parameter int NPADS = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_size,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             safe_mode,
  input  logic [NPADS-1:0] alt_out,
  input  logic [NPADS-1:0] alt_oe,
  output logic [NPADS-1:0] alt_in,
  input  logic [NPADS-1:0] pad_ext,
  output logic [NPADS-1:0] pad_drv_en,
  output logic [NPADS-1:0] pad_drv_val,
  output logic [NPADS-1:0] pad_slew,
  output logic [NPADS-1:0] pad_level
);
  localparam int NW = (NPADS + 31) / 32;
  localparam int CW = 7;

  logic [CW-1:0]    cfg [NPADS];
  logic [NW*32-1:0] dout_q;
  logic [NW*32-1:0] impl;
  logic [NPADS-1:0] din_sync;
  logic [NPADS-1:0] safe_vec, od_vec;
  logic [NW*32-1:0] din_ext;

  wire [3:0] region = bus_addr[11:8];
  wire [5:0] idx    = bus_addr[7:2];
  wire       wr     = bus_sel & bus_we;
  wire       rd     = bus_sel & ~bus_we;

  logic [4:0]  shift;
  logic [31:0] lane;
  always_comb begin
    case (bus_size)
      2'd0:    begin lane = 32'h0000_00ff; shift = 5'((3 - int'(bus_addr[1:0])) * 8); end
      2'd1:    begin lane = 32'h0000_ffff; shift = bus_addr[1] ? 5'd0 : 5'd16; end
      default: begin lane = 32'hffff_ffff; shift = 5'd0; end
    endcase
  end

  wire [31:0] wmask = lane << shift;
  wire [31:0] walgn = bus_wdata << shift;

  assign din_ext = (NW*32)'(din_sync);

  genvar w, p;
  generate
    for (w = 0; w < NW; w++) begin : g_word
      localparam logic [31:0] IM = (NPADS >= 32*(w+1)) ? 32'hffff_ffff
                                   : ((32'd1 << (NPADS - 32*w)) - 32'd1);
      assign impl[w*32 +: 32] = IM;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          dout_q[w*32 +: 32] <= '0;
        else if (wr && region == 4'd1 && idx == 6'(w))
          dout_q[w*32 +: 32] <= ((dout_q[w*32 +: 32] & ~wmask) | (walgn & wmask)) & IM;
    end

    for (p = 0; p < NPADS; p++) begin : g_pad
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          cfg[p] <= '0;
        else if (wr && region == 4'd0 && idx == 6'(p))
          cfg[p] <= bus_wdata[CW-1:0];

      wire alt_sel = cfg[p][0];
      wire src_val = alt_sel ? alt_out[p] : dout_q[p];
      wire src_oe  = alt_sel ? alt_oe[p]  : cfg[p][1];
      assign od_vec[p]      = cfg[p][2];
      assign safe_vec[p]    = cfg[p][6];
      assign pad_drv_en[p]  = src_oe & ~(safe_mode & safe_vec[p]) & ~(od_vec[p] & src_val);
      assign pad_drv_val[p] = src_val & ~od_vec[p];
      assign pad_slew[p]    = cfg[p][5];
      assign pad_level[p]   = pad_drv_en[p] ? pad_drv_val[p]
                            : cfg[p][3]     ? cfg[p][4] : pad_ext[p];
    end
  endgenerate

  assign alt_in = pad_level;

  always_ff @(posedge clk) din_sync <= pad_level;

  logic [31:0] word, rval;
  always_comb begin
    word = '0;
    rval = '0;
    case (region)
      4'd0: begin
        for (int i = 0; i < NPADS; i++)
          if (idx == 6'(i)) word = 32'(cfg[i]);
        rval = word;
      end
      4'd1, 4'd2: begin
        for (int i = 0; i < NW; i++)
          if (idx == 6'(i))
            word = (region == 4'd1 ? dout_q[i*32 +: 32] : din_ext[i*32 +: 32]) & impl[i*32 +: 32];
        rval = (word & wmask) >> shift;
      end
      default: rval = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rval;
endmodule

module gpio_portctl_chk #(
  parameter int NPADS = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [11:0]      bus_addr,
  input logic [31:0]      bus_rdata,
  input logic             safe_mode,
  input logic [NPADS-1:0] safe_vec,
  input logic [NPADS-1:0] od_vec,
  input logic [NPADS-1:0] pad_drv_en,
  input logic [NPADS-1:0] pad_drv_val,
  input logic [NPADS-1:0] pad_level,
  input logic [NPADS-1:0] din_sync
);
  assert_safe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    safe_mode |-> ((pad_drv_en & safe_vec) == '0));

  assert_od_no_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_drv_en & od_vec & pad_drv_val) == '0));

  assert_sync_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> din_sync == $past(pad_level));

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr[11:8] > 4'd2) |=> bus_rdata == 32'd0);

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> $stable(bus_rdata));
endmodule

bind gpio_portctl gpio_portctl_chk #(.NPADS(NPADS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .safe_mode(safe_mode),
  .safe_vec(safe_vec), .od_vec(od_vec), .pad_drv_en(pad_drv_en),
  .pad_drv_val(pad_drv_val), .pad_level(pad_level), .din_sync(din_sync)
);

// File: tb/gpio_portctl_test.sv
`timescale 1ns/1ps
module gpio_portctl_test;
  localparam int NP = 48;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [1:0] bus_size = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic safe_mode = 0;
  logic [NP-1:0] alt_out = '0, alt_oe = '0, pad_ext = '0;
  logic [NP-1:0] alt_in, pad_drv_en, pad_drv_val, pad_slew, pad_level;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #2 clk = ~clk;

  gpio_portctl #(.NPADS(NP)) uut (.*);

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [1:0] s, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] s, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_sel = 1; bus_we = 0; bus_addr = a; bus_size = s;
    @(negedge clk);
    bus_sel = 0;
  endtask

  initial forever begin
    @(posedge clk);
    if (bus_sel && !bus_we) begin
      @(negedge clk);
      chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_rdata, 0, "R1 rdata reset");
    chk(32'(pad_drv_en), 0, "R1 drivers off");
    rd(12'h100, 2, 0, "R1 dout reset");
    rd(12'h010, 2, 0, "R1 cfg reset");

    wr(12'h100, 2, 32'h1234_5678);
    rd(12'h100, 2, 32'h1234_5678, "R2 word read");
    rd(12'h100, 0, 32'h12, "R3 byte off0");
    rd(12'h103, 0, 32'h78, "R3 byte off3");
    rd(12'h100, 1, 32'h1234, "R4 half off0");
    rd(12'h102, 1, 32'h5678, "R4 half off2");
    wr(12'h101, 0, 32'hFFFF_FFAB);
    rd(12'h100, 2, 32'h12AB_5678, "R3 byte write lane");
    wr(12'h102, 1, 32'h0000_CDEF);
    rd(12'h100, 2, 32'h12AB_CDEF, "R4 half write lane");

    wr(12'h104, 2, 32'hFFFF_FFFF);
    rd(12'h104, 2, 32'h0000_FFFF, "R12 partial port");
    wr(12'h108, 2, 32'hFFFF_FFFF);
    rd(12'h108, 2, 0, "R12 port beyond pads");
    wr(12'h300, 2, 32'hFFFF_FFFF);
    rd(12'h300, 2, 0, "R12 window 3");
    rd(12'h100, 2, 32'h12AB_CDEF, "R12 writes ignored");

    wr(12'h000, 0, 32'h0000_007F);
    rd(12'h000, 2, 32'h7F, "R5 cfg readback");
    wr(12'h0C0, 2, 32'h7F);
    rd(12'h0C0, 2, 0, "R12 cfg beyond pads");

    pad_ext = '1;
    wr(12'h000, 2, 32'h02);
    chk(32'(pad_drv_en[0]), 1, "R6 gpio oe");
    chk(32'(pad_level[0]), 1, "R6 gpio value");
    wr(12'h010, 2, 32'h02);
    chk(32'(pad_level[4]), 0, "R6 gpio drives 0");

    wr(12'h000, 2, 32'h06);
    chk(32'(pad_drv_en[0]), 0, "R8 od releases 1");
    wr(12'h010, 2, 32'h06);
    chk(32'({pad_drv_en[4], pad_drv_val[4]}), 32'b10, "R8 od drives 0");
    wr(12'h000, 2, 32'h0E);
    pad_ext[0] = 0; #1;
    chk(32'(pad_level[0]), 0, "R10 pull down");
    wr(12'h000, 2, 32'h1E);
    chk(32'(pad_level[0]), 1, "R10 pull up");
    pad_ext[0] = 1;
    wr(12'h004, 2, 32'h08);
    chk(32'(pad_level[1]), 0, "R10 pull down over ext");
    chk(32'(pad_level[2]), 1, "R10 no pull follows ext");

    wr(12'h000, 2, 32'h42);
    chk(32'(pad_drv_en[0]), 1, "R9 safe idle");
    safe_mode = 1; #1;
    chk(32'(pad_drv_en[0]), 0, "R9 safe off");
    chk(32'(pad_drv_en[4]), 1, "R9 other pad kept");
    safe_mode = 0;

    alt_oe[3] = 1; alt_out[3] = 0;
    wr(12'h00C, 2, 32'h01);
    chk(32'({pad_drv_en[3], pad_level[3], alt_in[3]}), 32'b100, "R7 alt drives 0");
    alt_oe[3] = 0; #1;
    chk(32'({pad_drv_en[3], alt_in[3]}), 32'b01, "R7 alt released");

    wr(12'h000, 2, 32'h20);
    chk(32'(pad_slew[0]), 1, "R5 slew bit");

    wr(12'h000, 2, 0);
    wr(12'h004, 2, 0);
    wr(12'h00C, 2, 0);
    wr(12'h010, 2, 0);
    pad_ext = 48'h1234_89AB_CDEF;
    repeat (2) @(negedge clk);
    pad_ext = 48'h5678_0F0F_F0F0;
    rd(12'h200, 2, 32'h89AB_CDEF, "R11 sync lag");
    rd(12'h200, 2, 32'h0F0F_F0F0, "R11 new level");
    rd(12'h204, 2, 32'h0000_5678, "R11 upper port");
    rd(12'h201, 0, 32'h0F, "R11 byte view");
    repeat (3) @(negedge clk);
    chk(bus_rdata, 32'h0F, "R13 rdata held");

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule